// File: doc/BRIEF.md
# APB Interrupt Controller with Pulse Latching

This block collects up to 64 interrupt request lines and presents a single request to the CPU. Each line feeds a sticky flag bit. Any cycle in which the line is high sets the bit. The bit stays set until software clears it. Because of this, a one-cycle pulse is never missed, and a line that stays high keeps its flag set. Each flag is qualified by a per-source enable bit to form a pending bit. The CPU request is the OR of all pending bits, gated by one global enable bit.

Software reaches the block through an APB-style register port with no wait states. The 64 sources are split into a lower half (0–31) and an upper half (32–63). Each half has an enable register, a read-only pending register, and a flag register. The flag register sits eight bytes below that half's enable register. A 64-entry table of one byte per slot records which source number each slot carries. Software sets this table, and it resets to the identity mapping. The intended service loop reads the upper pending half and then the lower half. It clears the highest set bit it finds and scans again until both halves read zero.

Top module: `apb_irq_ctl`

## Requirements
- R1: After reset, every enable bit, flag bit and the global enable are 0, `irq_o` is low, and slot table word w reads {4w+3, 4w+2, 4w+1, 4w} (slot 4w+k in bits 8k+7:8k).
- R2: The enable registers at 0x10 (sources 0–31, bit n = source n) and 0x28 (sources 32–63, bit n = source 32+n) are read/write and hold their value when not written.
- R3: A source input sampled high on a clock edge sets its flag bit. The flag stays set after the input returns low. Flags read at 0x08 (lower half) and 0x20 (upper half).
- R4: A write to a flag register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. A write never sets a flag.
- R5: When a write clears a flag on the same edge that its source is high, the flag stays set.
- R6: The pending registers at 0x14 and 0x2C read as flag AND enable for their half. Writes to them have no effect.
- R7: Bit 31 of the control register at 0x00 is the global enable, and the other bits read 0. `irq_o` is high exactly when this bit is 1 and at least one pending bit is 1.
- R8: The slot table covers 0x40–0x7C as 16 read/write words of four 8-bit slot entries each.
- R9: Reads of unmapped or non-word-aligned addresses return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid combinationally during the access |
| src_i | input | 64 | Interrupt request lines, one per source |
| irq_o | output | 1 | Request to the CPU |

## Verification
Every one of the 64 sources is pulsed alone for a single cycle. Only its own flag bit and only its own half may respond, which tells apart crossed halves, shifted bit positions and a flag that follows the input instead of latching it. For each source, the enable and global enable are stepped through off, enable-only and both. This separates the gating of pending from the gating of `irq_o`. Three sources spread across both halves are then served by the highest-first software loop, which checks that clearing one flag leaves the others intact. The same-edge clear and pulse case is tried alone. Aligned holes, the word just past the table and misaligned addresses are written with all ones and read back, to catch decode aliasing.

// File: rtl/apb_irq_pkg.sv
package apb_irq_pkg;
    // Register map (byte offsets)
    localparam int unsigned CTRL_OFF  = 0;
    localparam int unsigned EN_BASE   = 16;  // enable of half 0
    localparam int unsigned EN_STRIDE = 24;  // distance between halves
    localparam int unsigned PEND_GAP  = 4;   // pending sits above enable
    localparam int unsigned FLAG_GAP  = 8;   // flag sits below enable
    localparam int unsigned SLOT_BASE = 64;
    localparam int unsigned GEN_BIT   = 31;

    typedef struct packed {
        logic gen;
    } ctrl_t;
endpackage

// File: rtl/apb_irq_half.sv
module apb_irq_half #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         flag_we_i,
    input  logic         en_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] en;
    } half_t;

    half_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i) begin
            st_d.en = wdata_i;
        end
        if (flag_we_i) begin
            st_d.flag = st_q.flag & wdata_i;   // zero bits clear, ones keep
        end
        st_d.flag = st_d.flag | src_i;         // a live request wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign en_o   = st_q.en;
    assign pend_o = st_q.flag & st_q.en;
endmodule

// File: rtl/apb_irq_slots.sv
module apb_irq_slots #(
    parameter int unsigned SLOTS  = 64,
    parameter int unsigned SLOT_W = 8,
    parameter int unsigned W      = 32,
    parameter int unsigned IDX_W  = $clog2(SLOTS / (W / SLOT_W))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [W-1:0]     wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [W-1:0]     rdata_o
);
    localparam int unsigned PER   = W / SLOT_W;
    localparam int unsigned WORDS = SLOTS / PER;

    typedef struct packed {
        logic [WORDS-1:0][W-1:0] words;
    } tbl_t;

    function automatic tbl_t identity();
        tbl_t v;
        v = '0;
        for (int w = 0; w < WORDS; w++) begin
            for (int k = 0; k < PER; k++) begin
                v.words[w][k*SLOT_W +: SLOT_W] = SLOT_W'(w * PER + k);
            end
        end
        return v;
    endfunction

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.words[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= identity();
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.words[ridx_i];
endmodule

// File: rtl/apb_irq_ctl.sv
module apb_irq_ctl
    import apb_irq_pkg::*;
#(
    parameter int unsigned NSRC   = 64,
    parameter int unsigned AW     = 8,
    parameter int unsigned DW     = 32,
    parameter int unsigned NSLOT  = 64,
    parameter int unsigned SLOT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [AW-1:0]   paddr,
    input  logic [DW-1:0]   pwdata,
    output logic [DW-1:0]   prdata,
    input  logic [NSRC-1:0] src_i,
    output logic            irq_o
);
    localparam int unsigned HALVES = NSRC / DW;
    localparam int unsigned WORDS  = NSLOT / (DW / SLOT_W);
    localparam int unsigned IDX_W  = $clog2(WORDS);
    localparam logic [AW-1:0] SLOT_LO = AW'(SLOT_BASE);
    localparam logic [AW-1:0] SLOT_HI = AW'(SLOT_BASE + WORDS * 4);

    function automatic logic [AW-1:0] en_off(input int unsigned h);
        return AW'(EN_BASE + EN_STRIDE * h);
    endfunction
    function automatic logic [AW-1:0] flag_off(input int unsigned h);
        return AW'(EN_BASE + EN_STRIDE * h - FLAG_GAP);
    endfunction
    function automatic logic [AW-1:0] pend_off(input int unsigned h);
        return AW'(EN_BASE + EN_STRIDE * h + PEND_GAP);
    endfunction

    // Decode
    logic              wr_acc, aligned, ctrl_hit, slot_hit;
    logic [HALVES-1:0] hit_en, hit_flag, hit_pend;
    logic [IDX_W-1:0]  slot_idx;

    always_comb begin
        wr_acc   = psel && penable && pwrite;
        aligned  = (paddr[1:0] == 2'b00);
        ctrl_hit = aligned && (paddr == AW'(CTRL_OFF));
        slot_hit = aligned && (paddr >= SLOT_LO) && (paddr < SLOT_HI);
        slot_idx = IDX_W'((paddr - SLOT_LO) >> 2);
        for (int h = 0; h < HALVES; h++) begin
            hit_en[h]   = aligned && (paddr == en_off(h));
            hit_flag[h] = aligned && (paddr == flag_off(h));
            hit_pend[h] = aligned && (paddr == pend_off(h));
        end
    end

    // Control register
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_acc && ctrl_hit) begin
            ctrl_d.gen = pwdata[GEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Source halves
    logic [NSRC-1:0] flag_all, en_all, pend_all;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        apb_irq_half #(.W(DW)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[h*DW +: DW]),
            .flag_we_i (wr_acc && hit_flag[h]),
            .en_we_i   (wr_acc && hit_en[h]),
            .wdata_i   (pwdata),
            .flag_o    (flag_all[h*DW +: DW]),
            .en_o      (en_all[h*DW +: DW]),
            .pend_o    (pend_all[h*DW +: DW])
        );
    end

    // Slot table
    logic [DW-1:0] slot_rdata;

    apb_irq_slots #(
        .SLOTS  (NSLOT),
        .SLOT_W (SLOT_W),
        .W      (DW),
        .IDX_W  (IDX_W)
    ) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_acc && slot_hit),
        .widx_i  (slot_idx),
        .wdata_i (pwdata),
        .ridx_i  (slot_idx),
        .rdata_o (slot_rdata)
    );

    // Read mux
    always_comb begin
        prdata = '0;
        if (ctrl_hit) begin
            prdata[GEN_BIT] = ctrl_q.gen;
        end
        for (int h = 0; h < HALVES; h++) begin
            if (hit_en[h])   prdata = en_all[h*DW +: DW];
            if (hit_flag[h]) prdata = flag_all[h*DW +: DW];
            if (hit_pend[h]) prdata = pend_all[h*DW +: DW];
        end
        if (slot_hit) begin
            prdata = slot_rdata;
        end
    end

    assign irq_o = ctrl_q.gen && (|pend_all);
endmodule

// File: rtl/apb_irq_ctl_chk.sv
module apb_irq_ctl_chk #(
    parameter int unsigned NSRC = 64,
    parameter int unsigned AW   = 8,
    parameter int unsigned DW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            psel,
    input logic            penable,
    input logic            pwrite,
    input logic [AW-1:0]   paddr,
    input logic [DW-1:0]   prdata,
    input logic [NSRC-1:0] src_i,
    input logic            irq_o,
    input logic            gen,
    input logic [NSRC-1:0] flag,
    input logic [NSRC-1:0] en
);
    AST_FLAG_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag & $past(src_i)) == $past(src_i))); // R3

    AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flag & ~$past(flag) & ~$past(src_i)) == '0)); // R4

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(en)); // R2

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !irq_o); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en != '0)); // R6

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && (paddr[1:0] != 2'b00)) |-> (prdata == '0)); // R9
endmodule

bind apb_irq_ctl apb_irq_ctl_chk #(
    .NSRC (NSRC),
    .AW   (AW),
    .DW   (DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .src_i   (src_i),
    .irq_o   (irq_o),
    .gen     (ctrl_q.gen),
    .flag    (flag_all),
    .en      (en_all)
);

// File: tb/apb_irq_ctl_test.sv
module apb_irq_ctl_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [63:0] src = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    apb_irq_ctl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .src_i   (src),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src[s] = 1'b1;
        @(negedge clk);
        src[s] = 1'b0;
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk);
        #1 chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    function automatic int top_bit(input logic [31:0] v);
        int r = -1;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int served [0:7];
        int nserved;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        irq_chk("R1 irq", 1'b0);
        rchk("R1 ctrl", 8'h00, 32'h0);
        rchk("R1 en_lo", 8'h10, 32'h0);
        rchk("R1 en_hi", 8'h28, 32'h0);
        rchk("R1 flag_lo", 8'h08, 32'h0);
        rchk("R1 flag_hi", 8'h20, 32'h0);
        for (int w = 0; w < 16; w++) begin
            rchk("R1 slot identity", 8'(8'h40 + 4*w),
                 {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        end

        // R2: enable read/write
        wr(8'h10, 32'hA5A5_5A5A);
        wr(8'h28, 32'h0F0F_F0F0);
        rchk("R2 en_lo", 8'h10, 32'hA5A5_5A5A);
        rchk("R2 en_hi", 8'h28, 32'h0F0F_F0F0);
        wr(8'h10, 32'h0);
        wr(8'h28, 32'h0);
        rchk("R2 en_lo zero", 8'h10, 32'h0);

        // Sweep over every source
        for (int s = 0; s < 64; s++) begin
            automatic int b = s % 32;
            automatic logic [7:0] fo = (s < 32) ? 8'h08 : 8'h20;
            automatic logic [7:0] fx = (s < 32) ? 8'h20 : 8'h08;
            automatic logic [7:0] eo = (s < 32) ? 8'h10 : 8'h28;
            automatic logic [7:0] po = (s < 32) ? 8'h14 : 8'h2C;
            automatic logic [31:0] m = 32'h1 << b;
            pulse(s);
            rchk("R3 own flag", fo, m);
            rchk("R3 other half", fx, 32'h0);
            rchk("R6 pend disabled", po, 32'h0);
            wr(eo, m);
            rchk("R6 pend enabled", po, m);
            irq_chk("R7 irq gen off", 1'b0);
            wr(8'h00, 32'h8000_0000);
            irq_chk("R7 irq gen on", 1'b1);
            wr(fo, 32'hFFFF_FFFF);
            rchk("R4 ones keep", fo, m);
            wr(fo, ~m);
            rchk("R4 zero clears", fo, 32'h0);
            irq_chk("R7 irq after clear", 1'b0);
            wr(8'h00, 32'h0);
            wr(eo, 32'h0);
        end

        // R5: clear and new request on the same edge
        pulse(3);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h08; pwdata = 32'h0;
        @(negedge clk);
        penable = 1'b1; src[3] = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; src[3] = 1'b0;
        rchk("R5 flag kept", 8'h08, 32'h0000_0008);
        wr(8'h08, 32'h0);
        rchk("R5 later clear", 8'h08, 32'h0);

        // R6: pending registers ignore writes
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rchk("R6 pend_lo", 8'h14, 32'h0);
        rchk("R6 pend_hi", 8'h2C, 32'h0);
        rchk("R6 flag_lo", 8'h08, 32'h0);
        rchk("R6 en_hi", 8'h28, 32'h0);

        // R7: only bit 31 of control is stored
        wr(8'h00, 32'hFFFF_FFFF);
        rchk("R7 ctrl readback", 8'h00, 32'h8000_0000);
        wr(8'h00, 32'h7FFF_FFFF);
        rchk("R7 ctrl cleared", 8'h00, 32'h0);

        // R8: slot table read/write
        for (int w = 0; w < 16; w++) wr(8'(8'h40 + 4*w), (32'h0101_0101 * w) ^ 32'hC33C_5AA5);
        for (int w = 0; w < 16; w++)
            rchk("R8 slot word", 8'(8'h40 + 4*w), (32'h0101_0101 * w) ^ 32'hC33C_5AA5);

        // R9: unmapped and misaligned
        wr(8'h10, 32'h0000_1234);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rchk("R9 read 0x04", 8'h04, 32'h0);
        rchk("R9 read 0x30", 8'h30, 32'h0);
        rchk("R9 read 0x80", 8'h80, 32'h0);
        rchk("R9 read 0xFC", 8'hFC, 32'h0);
        rchk("R9 misaligned read", 8'h12, 32'h0);
        rchk("R9 en_lo untouched", 8'h10, 32'h0000_1234);
        rchk("R9 ctrl untouched", 8'h00, 32'h0);
        rchk("R9 slot last untouched", 8'h7C, (32'h0101_0101 * 15) ^ 32'hC33C_5AA5);
        wr(8'h10, 32'h0);

        // R7: highest-first service loop over both halves
        pulse(5);
        pulse(40);
        pulse(63);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h00, 32'h8000_0000);
        irq_chk("R7 irq three pending", 1'b1);
        nserved = 0;
        for (int it = 0; it < 8; it++) begin
            automatic int b;
            rd(8'h2C, v);
            if (v != 0) begin
                b = top_bit(v);
                served[nserved] = 32 + b;
                nserved++;
                wr(8'h20, ~(32'h1 << b));
            end else begin
                rd(8'h14, v);
                if (v == 0) break;
                b = top_bit(v);
                served[nserved] = b;
                nserved++;
                wr(8'h08, ~(32'h1 << b));
            end
        end
        chk("R7 served count", 32'(nserved), 32'd3);
        chk("R7 first served", 32'(served[0]), 32'd63);
        chk("R7 second served", 32'(served[1]), 32'd40);
        chk("R7 third served", 32'(served[2]), 32'd5);
        irq_chk("R7 irq all served", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule